// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block produces the pin-level timing of the external memory bus of an 8051-style controller. Time is counted in machine cycles of twelve clock periods, six states each cut into two phases. At the last phase of a machine cycle the block takes one request from the core: a code fetch, a data read or a data write. During the following machine cycle it drives the latch strobe, the code strobe and the read and write strobes. Port 0 carries the low address byte and then either floats for incoming bytes or drives write data. Port 2 carries the high address byte or the port register value.

A code fetch cycle reads two successive bytes, at the given address and the address plus one. A data cycle fits one transfer in the whole machine cycle, so one latch pulse and both code-strobe pulses are left out. Bytes that arrive on port 0 are captured into a holding register with a one-cycle valid pulse. The core decodes instructions; this block only sequences the bus.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is high the outputs are idle: latch strobe 0, code strobe, read strobe and write strobe 1, port 0 enable 0, port 0 and port 2 values 0, valid and both acknowledges 0. The first machine cycle after reset is an idle cycle.
- R2: A machine cycle lasts 12 clock periods, phases 0 to 11. In idle and fetch cycles the latch strobe is high in phases 0, 1, 6 and 7 and low otherwise. An idle cycle drives nothing on port 0 and shows the latched port register on port 2.
- R3: In a fetch cycle for address A the code strobe (active low) is low in phases 2-4 and 8-10. Port 0 drives A[7:0] in phases 0-1 and (A+1)[7:0] in phases 6-7. Port 2 shows A[15:8] in phases 0-5 and (A+1)[15:8] in phases 6-11.
- R4: In a data cycle the latch strobe is high only in phases 0 and 1, the code strobe stays high for all 12 phases, and port 0 drives the low data address byte in phases 0-1.
- R5: In a read cycle the read strobe (active low) is low in phases 3-9 and port 0 floats from phase 2. The byte on the port 0 input at the end of phase 9 appears on the captured-data output with the valid output high during phase 10 only.
- R6: In a write cycle the write strobe (active low) is low in phases 3-9, and port 0 drives the write byte in phases 2-10 and floats in phase 11.
- R7: In a data cycle with the wide flag at 1, port 2 shows the high data address byte for the whole cycle. With the flag at 0 it shows the port register value sampled with the request.
- R8: Requests are sampled at the end of phase 11. A data request wins over a fetch request. The fetch or data acknowledge is high in phase 0 of the cycle that serves it.
- R9: The read and write strobes are never low together, and port 0's output value is 0 whenever its enable is low.
- R10: In a fetch cycle the port 0 input is captured at the end of phases 4 and 10, with the valid output high in phases 5 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Code fetch request |
| fetch_addr | input | 16 | Code address of the first byte |
| data_req | input | 1 | Data access request |
| data_we | input | 1 | 1 = write, 0 = read |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| data_addr | input | 16 | Data address |
| data_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | Port 2 register value |
| p0_in | input | 8 | Port 0 pin input |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 drive value |
| rd_data | output | 8 | Captured port 0 byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data updated |
| fetch_ack | output | 1 | Fetch request taken |
| data_ack | output | 1 | Data request taken |

## Verification
Every pin is compared in every phase of a sequence that walks idle, fetch, wide and narrow reads, wide and narrow writes, and simultaneous fetch and data requests. A fetch at an address whose low byte is all ones shows whether the second address carries into port 2. The narrow accesses use a port register value unrelated to the address, which exposes a wrong port 2 source. A reset in the middle of a request, followed by the delayed acknowledge, shows whether sampling is tied to phase 11.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
    parameter int ADDR_W    = 16;
    parameter int DATA_W    = 8;
    parameter int STATES    = 6;
    parameter int PH_PER_ST = 2;
    localparam int PHASES   = STATES * PH_PER_ST;
    localparam int PH_W     = $clog2(PHASES);
    localparam int HALF     = PHASES / 2;
    localparam int HI_W     = ADDR_W - DATA_W;

    // phase windows (inclusive)
    localparam int ALE_LO   = 0;
    localparam int ALE_HI   = 1;
    localparam int PS_LO    = 2;
    localparam int PS_HI    = 4;
    localparam int XS_LO    = 3;
    localparam int XS_HI    = HALF + 3;
    localparam int WD_LO    = 2;
    localparam int WD_HI    = PHASES - 2;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e          kind;
        logic               wide;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  p2v;
    } cyc_cmd_t;

    function automatic logic in_win(input logic [PH_W-1:0] ph, input int lo, input int hi);
        return (int'(ph) >= lo) && (int'(ph) <= hi);
    endfunction
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr
    import ext_bus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            live,
    output logic            cyc_end
);
    logic [PH_W-1:0] ph_q;
    logic            live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            live_q <= 1'b0;
        end else if (!live_q) begin
            live_q <= 1'b1;
        end else if (int'(ph_q) == PHASES - 1) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign ph      = ph_q;
    assign live    = live_q;
    assign cyc_end = live_q && (int'(ph_q) == PHASES - 1);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (live_q && int'(ph_q) == PHASES - 1) |=> (ph_q == '0)); // R2
endmodule

// File: rtl/bus_cmd_latch.sv
module bus_cmd_latch
    import ext_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_end,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic [DATA_W-1:0] p2_latch,
    output cyc_cmd_t          cmd
);
    cyc_cmd_t cmd_q, cmd_nx;

    always_comb begin
        cmd_nx       = '0;
        cmd_nx.p2v   = p2_latch;
        cmd_nx.wdata = data_wdata;
        if (data_req) begin
            cmd_nx.kind = data_we ? CYC_WRITE : CYC_READ;
            cmd_nx.wide = data_wide;
            cmd_nx.addr = data_addr;
        end else if (fetch_req) begin
            cmd_nx.kind = CYC_FETCH;
            cmd_nx.wide = 1'b1;
            cmd_nx.addr = fetch_addr;
        end else begin
            cmd_nx.kind = CYC_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          cmd_q <= '0;
        else if (cyc_end) cmd_q <= cmd_nx;
    end

    assign cmd = cmd_q;

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> $stable(cmd_q)); // R8
endmodule

// File: rtl/bus_pin_gen.sv
module bus_pin_gen
    import ext_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   ph,
    input  logic              live,
    input  cyc_cmd_t          cmd,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fetch_ack,
    output logic              data_ack
);
    logic [ADDR_W-1:0] addr_nx;
    logic              is_data, first_lat, second_lat, cap;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    assign addr_nx    = cmd.addr + 1'b1;
    assign is_data    = (cmd.kind == CYC_READ) || (cmd.kind == CYC_WRITE);
    assign first_lat  = in_win(ph, ALE_LO, ALE_HI);
    assign second_lat = in_win(ph, ALE_LO + HALF, ALE_HI + HALF);

    always_comb begin
        ale       = 1'b0;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        p0_out    = '0;
        p0_oe     = 1'b0;
        p2_out    = '0;
        fetch_ack = 1'b0;
        data_ack  = 1'b0;
        if (live) begin
            ale       = first_lat || (second_lat && !is_data);
            fetch_ack = (cmd.kind == CYC_FETCH) && (ph == '0);
            data_ack  = is_data && (ph == '0);
            p2_out    = cmd.p2v;
            unique case (cmd.kind)
                CYC_FETCH: begin
                    psen_n = !(in_win(ph, PS_LO, PS_HI) || in_win(ph, PS_LO + HALF, PS_HI + HALF));
                    if (first_lat) begin
                        p0_oe  = 1'b1;
                        p0_out = cmd.addr[DATA_W-1:0];
                    end else if (second_lat) begin
                        p0_oe  = 1'b1;
                        p0_out = addr_nx[DATA_W-1:0];
                    end
                    p2_out = (int'(ph) < HALF) ? cmd.addr[ADDR_W-1:DATA_W]
                                               : addr_nx[ADDR_W-1:DATA_W];
                end
                CYC_READ, CYC_WRITE: begin
                    if (cmd.wide) p2_out = cmd.addr[ADDR_W-1:DATA_W];
                    if (first_lat) begin
                        p0_oe  = 1'b1;
                        p0_out = cmd.addr[DATA_W-1:0];
                    end
                    if (cmd.kind == CYC_READ) begin
                        rd_n = !in_win(ph, XS_LO, XS_HI);
                    end else begin
                        wr_n = !in_win(ph, XS_LO, XS_HI);
                        if (in_win(ph, WD_LO, WD_HI)) begin
                            p0_oe  = 1'b1;
                            p0_out = cmd.wdata;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // capture on the last phase of each incoming-byte strobe
    assign cap = live && (((cmd.kind == CYC_FETCH) &&
                           (int'(ph) == PS_HI || int'(ph) == PS_HI + HALF)) ||
                          ((cmd.kind == CYC_READ) && int'(ph) == XS_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= cap;
            if (cap) rd_data_q <= p0_in;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R9
    AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !p0_oe |-> (p0_out == '0)); // R9
    AST_NO_CODE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        is_data |-> psen_n); // R4
    AST_VALID_ON_RD_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> rd_valid); // R5
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic [DATA_W-1:0] p2_latch,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fetch_ack,
    output logic              data_ack
);
    logic [PH_W-1:0] ph;
    logic            live, cyc_end;
    cyc_cmd_t        cmd;

    bus_phase_ctr u_ph (
        .clk(clk), .rst(rst), .ph(ph), .live(live), .cyc_end(cyc_end)
    );

    bus_cmd_latch u_cmd (
        .clk(clk), .rst(rst), .cyc_end(cyc_end),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
        .data_addr(data_addr), .data_wdata(data_wdata), .p2_latch(p2_latch),
        .cmd(cmd)
    );

    bus_pin_gen u_pins (
        .clk(clk), .rst(rst), .ph(ph), .live(live), .cmd(cmd), .p0_in(p0_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .fetch_ack(fetch_ack), .data_ack(data_ack)
    );
endmodule

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req, data_req, data_we, data_wide;
    logic [15:0] fetch_addr, data_addr;
    logic [7:0]  data_wdata, p2_latch, p0_in;
    logic        ale, psen_n, rd_n, wr_n, p0_oe, rd_valid, fetch_ack, data_ack;
    logic [7:0]  p0_out, p2_out, rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ext_bus_seq dut_i (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
        .data_addr(data_addr), .data_wdata(data_wdata), .p2_latch(p2_latch),
        .p0_in(p0_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .rd_data(rd_data),
        .rd_valid(rd_valid), .fetch_ack(fetch_ack), .data_ack(data_ack)
    );

    typedef struct packed {
        logic f, d, we, wide;
        logic [15:0] fa, da;
        logic [7:0] wd, p2, pin;
    } vec_t;

    typedef struct packed {
        logic ale, psen_n, rd_n, wr_n, oe, fack, dack;
        logic [7:0] p0, p2;
    } pins_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'h00, 8'h44, 8'h00}, // idle
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h12FF, 16'h0000, 8'h00, 8'h21, 8'h6B}, // fetch, carry into high byte
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 8'h00, 8'h99, 8'h5A}, // wide read
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h3344, 8'hC3, 8'h77, 8'h00}, // narrow write
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h4000, 16'h5566, 8'h00, 8'h81, 8'hA5}, // both: data wins
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hFFFE, 8'h3C, 8'h12, 8'h00}, // wide write
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0040, 16'h0000, 8'h00, 8'h00, 8'h96}, // fetch
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'hA0B0, 8'h00, 8'h0F, 8'hE1}, // narrow read
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'h00, 8'h5D, 8'h00}  // idle
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic pins_t expect_pins(input vec_t v, input int k);
        pins_t p;
        logic [15:0] a1;
        bit dat, fet, rd, wr;
        dat = v.d;
        fet = v.f && !v.d;
        rd  = dat && !v.we;
        wr  = dat && v.we;
        a1  = v.fa + 16'd1;
        p = '0;
        p.ale    = (k < 2) || ((k == 6 || k == 7) && !dat);
        p.psen_n = !(fet && ((k >= 2 && k <= 4) || (k >= 8 && k <= 10)));
        p.rd_n   = !(rd && k >= 3 && k <= 9);
        p.wr_n   = !(wr && k >= 3 && k <= 9);
        p.fack   = fet && k == 0;
        p.dack   = dat && k == 0;
        p.p2     = v.p2;
        if (fet) begin
            p.p2 = (k < 6) ? v.fa[15:8] : a1[15:8];
            if (k < 2) begin p.oe = 1'b1; p.p0 = v.fa[7:0]; end
            if (k == 6 || k == 7) begin p.oe = 1'b1; p.p0 = a1[7:0]; end
        end
        if (dat) begin
            if (v.wide) p.p2 = v.da[15:8];
            if (k < 2) begin p.oe = 1'b1; p.p0 = v.da[7:0]; end
            if (wr && k >= 2 && k <= 10) begin p.oe = 1'b1; p.p0 = v.wd; end
        end
        return p;
    endfunction

    function automatic pins_t actual_pins();
        pins_t p;
        p.ale = ale; p.psen_n = psen_n; p.rd_n = rd_n; p.wr_n = wr_n;
        p.oe = p0_oe; p.fack = fetch_ack; p.dack = data_ack;
        p.p0 = p0_out; p.p2 = p2_out;
        return p;
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.f && v.d) return "R8 R4";
        if (v.d && v.we) return "R4 R6 R7";
        if (v.d) return "R4 R5 R7";
        if (v.f) return "R2 R3";
        return "R2";
    endfunction

    task automatic drive(input vec_t v);
        fetch_req = v.f; data_req = v.d; data_we = v.we; data_wide = v.wide;
        fetch_addr = v.fa; data_addr = v.da; data_wdata = v.wd; p2_latch = v.p2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t  prev;
        pins_t e, a;
        rst = 1'b1;
        drive('0);
        p0_in = 8'h00;
        repeat (3) @(negedge clk);
        // R1: idle pins during reset
        chk({ale, psen_n, rd_n, wr_n, p0_oe, rd_valid, fetch_ack, data_ack} == 8'b01110000 &&
            p0_out == 8'h00 && p2_out == 8'h00, "R1",
            {ale, psen_n, rd_n, wr_n, p0_oe, rd_valid, fetch_ack, data_ack}, 8'b01110000);
        rst = 1'b0;
        @(negedge clk);
        prev = '0;
        for (int v = 0; v <= NV; v++) begin
            vec_t cur;
            cur = (v < NV) ? VECS[v] : '0;
            drive(cur);
            p0_in = prev.pin;
            for (int k = 0; k < 12; k++) begin
                bit cap;
                e = expect_pins(prev, k);
                a = actual_pins();
                chk(a == e, tag_of(prev), a, e);
                chk(!(!rd_n && !wr_n) && (p0_oe || p0_out == 8'h00), "R9",
                    {rd_n, wr_n, p0_oe, p0_out}, {2'b11, p0_oe, 8'h00});
                // R5 read capture, R10 fetch capture
                cap = (prev.d && !prev.we && k == 10) || (prev.f && !prev.d && (k == 5 || k == 11));
                if (cap)
                    chk(rd_valid && rd_data == prev.pin, prev.d ? "R5" : "R10",
                        {rd_valid, rd_data}, {1'b1, prev.pin});
                else
                    chk(!rd_valid, "R5 R10", rd_valid, 0);
                @(negedge clk);
            end
            prev = cur;
        end
        // R8: reset while a request is pending; first cycle idle, request served next
        drive('{1'b0, 1'b1, 1'b0, 1'b1, 16'h0, 16'h7788, 8'h00, 8'h00, 8'h00});
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!ale && psen_n && !p0_oe && !data_ack && !rd_valid, "R1",
            {ale, psen_n, p0_oe, data_ack, rd_valid}, 5'b01000);
        rst = 1'b0;
        @(negedge clk);
        chk(ale && !data_ack && !fetch_ack && rd_n, "R1 R8",
            {ale, data_ack, fetch_ack, rd_n}, 4'b1001);
        repeat (12) @(negedge clk);
        chk(ale && data_ack && p2_out == 8'h77 && p0_out == 8'h88, "R8 R7",
            {ale, data_ack, p2_out, p0_out}, {2'b11, 8'h77, 8'h88});
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule